// File: doc/BRIEF.md
# Subset Instruction Decoder

This block turns one raw 32-bit instruction word into the control bundle an issue stage needs. It handles a small integer subset: add, logical AND/OR, word/halfword/byte/doubleword loads and stores, compare, the three 32-bit rotate-and-mask forms, relative and absolute branches, and a CR-bit AND. It is purely combinational. A runtime byte-order input decides whether the word is used as presented or byte-reversed first. Every later field extraction works on that corrected word.

The outputs cover several things. There is a 4-bit operation class. There are selects for one register write port and three register read ports, each with its own valid bit. There is a 64-bit immediate, already expanded. The flags cover record, update, link and absolute addressing, plus the memory access size. There are condition-register field selects and a branch-target special-register select. The raw BO, BI, SH, MB and ME fields are also passed out. The canonical all-zero OR form is reported as a no-op. Anything outside the subset raises an illegal flag and leaves no port valid.

Bit positions below count from 0 at the least significant bit of the corrected word.

Top module: `pwr_subset_decoder`

## Requirements
- R1: When `big_endian` is 1 the word is decoded as presented. When it is 0, bytes 0/3 and 1/2 are exchanged first. A word and its byte-reversed copy with the opposite `big_endian` give identical outputs.
- R2: The primary opcode is bits [31:26].
  - Opcodes 19 and 31 take an extended opcode from bits [10:1]. Opcodes 58 and 62 take it from bits [1:0].
  - Supported primaries: 14 addi, 15 addis, 24 ori, 25 oris, 28 andi., 32 lwz, 33 lwzu, 34 lbz, 40 lhz, 36 stw, 37 stwu, 38 stb, 44 sth, 18 b, 16 bc, 20 rlwimi, 21 rlwinm, 23 rlwnm, 58/0 ld, 62/0 std.
  - Under 31: 266 add, 28 and, 444 or, 23 lwzx, 151 stwx, 0 cmp. Under 19: 16 bclr, 528 bcctr, 257 crand.
  - `op_code` values: 0 illegal, 1 no-op, 2 add, 3 and, 4 or, 5 load, 6 store, 7 compare, 8 rotate, 9 branch, 10 CR logical.
- R3: A corrected word of exactly 0x60000000 gives `nop`=1, `op_code`=1 and no valid port. Other OR-immediate words, such as 0x64000000, decode normally.
- R4: Any other encoding gives `illegal`=1 and `op_code`=0. All valid bits, flags, the immediate, the size and the special-register select are then 0. Any select whose valid bit is 0 reads 0.
- R5: The immediate has several modes.
  - ori/andi. zero-extend bits [15:0]. oris places them at [31:16] with zeros elsewhere.
  - addi and D-form loads/stores sign-extend bits [15:0]. addis sign-extends bits [15:0] shifted left by 16.
  - ld/std sign-extend bits [15:2] followed by two zero bits.
  - Instructions with no immediate give 0.
- R6: The target field [25:21] routes differently for loads and stores.
  - For loads it drives the write select.
  - For stores it drives read port 3 and the write port stays invalid.
  - RA [20:16] drives read port 1. For addi, addis, non-update loads/stores, lwzx and stwx, RA=0 means literal zero and read port 1 is invalid.
- R7: For add, lwzx, stwx and cmp, RB [15:11] is on read port 2 and RA is on read port 1. For and, or, andi., ori and oris, RA is the write select and RS [25:21] is on read port 3. and/or also put RB on read port 2.
- R8: `rec` is 1 for andi. It follows bit 0 for add, and, or and the rotates. It is 0 for everything else.
- R9: `acc_size` is 8, 4, 2 or 1 for doubleword, word, halfword or byte accesses, and 0 for non-memory instructions. `upd` is 1 only for lwzu and stwu, which keep RA valid even when it is 0.
- R10: b gives an immediate equal to the sign-extended 24-bit field [25:2] times 4. bc gives the sign-extended 14-bit field [15:2] times 4. For both, `lnk` is bit 0 and `absb` is bit 1, and bc reads CR field BI/4 on CR read 1, with BI at [20:16].
- R11: bclr selects special register 1 (link) and bcctr selects 2 (count), with 0 meaning none. `lnk` is bit 0 and `absb` is 0. BI/4 is on CR read 1. `bo` and `bi` are the raw fields [25:21] and [20:16] for every word.
- R12: For crand, CR read 1 is BA/4 and CR read 2 is BB/4, with BA at [20:16] and BB at [15:11]. CR read 3 and the CR write select are both BT/4, with BT at [25:21]. For cmp, the CR write select is BF at [25:23].
- R13: For the rotates, RA is written and RS is on read port 3. rlwnm additionally reads RB on read port 2. `sh`, `mb` and `me` are the raw fields [15:11], [10:6] and [5:1] for every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_raw | input | 32 | Instruction word as fetched |
| big_endian | input | 1 | 1: use as presented, 0: reverse bytes |
| op_code | output | 4 | Operation class |
| illegal | output | 1 | Encoding outside the subset |
| nop | output | 1 | Canonical no-op detected |
| wr_sel | output | 5 | Register write select |
| wr_vld | output | 1 | Write select valid |
| rd1_sel | output | 5 | Read port 1 select |
| rd1_vld | output | 1 | Read port 1 valid |
| rd2_sel | output | 5 | Read port 2 select |
| rd2_vld | output | 1 | Read port 2 valid |
| rd3_sel | output | 5 | Read port 3 select |
| rd3_vld | output | 1 | Read port 3 valid |
| imm | output | 64 | Expanded immediate |
| rec | output | 1 | Record flag |
| upd | output | 1 | Base-update flag |
| lnk | output | 1 | Link flag |
| absb | output | 1 | Absolute-address flag |
| acc_size | output | 4 | Memory access bytes |
| spr_sel | output | 2 | Branch-target register: 0 none, 1 link, 2 count |
| crw_sel | output | 3 | CR field written |
| crw_vld | output | 1 | CR write valid |
| crr1_sel | output | 3 | CR read 1 field |
| crr1_vld | output | 1 | CR read 1 valid |
| crr2_sel | output | 3 | CR read 2 field |
| crr2_vld | output | 1 | CR read 2 valid |
| crr3_sel | output | 3 | CR read 3 field |
| crr3_vld | output | 1 | CR read 3 valid |
| bo | output | 5 | Raw BO field |
| bi | output | 5 | Raw BI field |
| sh | output | 5 | Raw SH field |
| mb | output | 5 | Raw MB field |
| me | output | 5 | Raw ME field |

## Verification
Byte reversal and no-op detection act on the same word in the same evaluation, so the bench drives words where the two interact. The word 0x00000060 with `big_endian`=0 must report a no-op. The word 0x60000000 with `big_endian`=0 reverses to primary opcode 0 and must report illegal. Every other instruction is also driven in both byte orders against one expected item, so routing depends only on the corrected word.

// File: rtl/pwr_dec_pkg.sv
package pwr_dec_pkg;

  typedef enum logic [3:0] {
    OPC_ILL = 4'd0, OPC_NOP = 4'd1, OPC_ADD = 4'd2, OPC_AND = 4'd3,
    OPC_OR = 4'd4, OPC_LOAD = 4'd5, OPC_STORE = 4'd6, OPC_CMP = 4'd7,
    OPC_ROT = 4'd8, OPC_BR = 4'd9, OPC_CRL = 4'd10
  } opc_e;

  typedef enum logic [2:0] {
    IMM_NONE, IMM_UI, IMM_UIH, IMM_SI, IMM_SIH, IMM_W14, IMM_LI
  } imm_e;

  typedef enum logic [1:0] {WR_NONE, WR_RT, WR_RA} wsrc_e;
  typedef enum logic [1:0] {R1_NONE, R1_RA, R1_RA0} r1src_e;
  typedef enum logic [1:0] {RC_ZERO, RC_ONE, RC_BIT} rcsrc_e;
  typedef enum logic [1:0] {CRM_NONE, CRM_CMP, CRM_BI, CRM_LOGIC} crmode_e;

  typedef struct packed {
    opc_e        op;
    wsrc_e       wr;
    r1src_e      r1;
    logic        r2_rb;
    logic        r3_rs;
    imm_e        imm;
    rcsrc_e      rc;
    crmode_e     cr;
    logic [1:0]  spr;
    logic [3:0]  size;
    logic        upd;
    logic        br;
    logic        aa_ok;
    logic        nop;
    logic        ill;
  } ctl_t;

  localparam logic [5:0] PO_BC = 6'd16, PO_B = 6'd18, PO_XL = 6'd19;
  localparam logic [5:0] PO_RLWIMI = 6'd20, PO_RLWINM = 6'd21, PO_RLWNM = 6'd23;
  localparam logic [5:0] PO_ADDI = 6'd14, PO_ADDIS = 6'd15;
  localparam logic [5:0] PO_ORI = 6'd24, PO_ORIS = 6'd25, PO_ANDI = 6'd28;
  localparam logic [5:0] PO_X = 6'd31;
  localparam logic [5:0] PO_LWZ = 6'd32, PO_LWZU = 6'd33, PO_LBZ = 6'd34;
  localparam logic [5:0] PO_STW = 6'd36, PO_STWU = 6'd37, PO_STB = 6'd38;
  localparam logic [5:0] PO_LHZ = 6'd40, PO_STH = 6'd44;
  localparam logic [5:0] PO_DSLD = 6'd58, PO_DSST = 6'd62;

  localparam logic [9:0] XO_ADD = 10'd266, XO_AND = 10'd28, XO_OR = 10'd444;
  localparam logic [9:0] XO_LWZX = 10'd23, XO_STWX = 10'd151, XO_CMP = 10'd0;
  localparam logic [9:0] XO_BCLR = 10'd16, XO_BCCTR = 10'd528, XO_CRAND = 10'd257;

  localparam logic [31:0] NOP_WORD = 32'h6000_0000;

  localparam logic [1:0] SPR_NONE = 2'd0, SPR_LINK = 2'd1, SPR_COUNT = 2'd2;

endpackage

// File: rtl/pwr_dec_swap.sv
module pwr_dec_swap #(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] raw,
  input  logic              big_endian,
  output logic [INSN_W-1:0] word
);
  localparam int NB = INSN_W / 8;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign word[8*i +: 8] = big_endian ? raw[8*i +: 8] : raw[8*(NB-1-i) +: 8];
  end
endmodule

// File: rtl/pwr_dec_class.sv
module pwr_dec_class
  import pwr_dec_pkg::*;
(
  input  logic [31:0] word,
  output ctl_t        ctl
);
  logic [5:0] prim;
  logic [9:0] xo10;
  logic [1:0] xo2;

  assign prim = word[31:26];
  assign xo10 = word[10:1];
  assign xo2  = word[1:0];

  function automatic ctl_t base(opc_e o);
    ctl_t c;
    c    = '0;
    c.op = o;
    return c;
  endfunction

  function automatic ctl_t ldst(logic st, logic [3:0] sz, logic up, imm_e im);
    ctl_t c;
    c = base(st ? OPC_STORE : OPC_LOAD);
    if (st) c.r3_rs = 1'b1;
    else    c.wr    = WR_RT;
    c.r1   = up ? R1_RA : R1_RA0;
    c.imm  = im;
    c.size = sz;
    c.upd  = up;
    return c;
  endfunction

  function automatic ctl_t logic_imm(opc_e o, imm_e im, rcsrc_e rc);
    ctl_t c;
    c       = base(o);
    c.wr    = WR_RA;
    c.r3_rs = 1'b1;
    c.imm   = im;
    c.rc    = rc;
    return c;
  endfunction

  function automatic ctl_t rotate(logic use_rb);
    ctl_t c;
    c       = base(OPC_ROT);
    c.wr    = WR_RA;
    c.r3_rs = 1'b1;
    c.r2_rb = use_rb;
    c.rc    = RC_BIT;
    return c;
  endfunction

  always_comb begin
    ctl     = base(OPC_ILL);
    ctl.ill = 1'b1;
    case (prim)
      PO_ADDI, PO_ADDIS: begin
        ctl     = base(OPC_ADD);
        ctl.wr  = WR_RT;
        ctl.r1  = R1_RA0;
        ctl.imm = (prim == PO_ADDI) ? IMM_SI : IMM_SIH;
      end
      PO_ORI:    ctl = logic_imm(OPC_OR, IMM_UI, RC_ZERO);
      PO_ORIS:   ctl = logic_imm(OPC_OR, IMM_UIH, RC_ZERO);
      PO_ANDI:   ctl = logic_imm(OPC_AND, IMM_UI, RC_ONE);
      PO_LWZ:    ctl = ldst(1'b0, 4'd4, 1'b0, IMM_SI);
      PO_LWZU:   ctl = ldst(1'b0, 4'd4, 1'b1, IMM_SI);
      PO_LBZ:    ctl = ldst(1'b0, 4'd1, 1'b0, IMM_SI);
      PO_LHZ:    ctl = ldst(1'b0, 4'd2, 1'b0, IMM_SI);
      PO_STW:    ctl = ldst(1'b1, 4'd4, 1'b0, IMM_SI);
      PO_STWU:   ctl = ldst(1'b1, 4'd4, 1'b1, IMM_SI);
      PO_STB:    ctl = ldst(1'b1, 4'd1, 1'b0, IMM_SI);
      PO_STH:    ctl = ldst(1'b1, 4'd2, 1'b0, IMM_SI);
      PO_DSLD:   if (xo2 == 2'd0) ctl = ldst(1'b0, 4'd8, 1'b0, IMM_W14);
      PO_DSST:   if (xo2 == 2'd0) ctl = ldst(1'b1, 4'd8, 1'b0, IMM_W14);
      PO_RLWIMI, PO_RLWINM: ctl = rotate(1'b0);
      PO_RLWNM:  ctl = rotate(1'b1);
      PO_B: begin
        ctl       = base(OPC_BR);
        ctl.imm   = IMM_LI;
        ctl.br    = 1'b1;
        ctl.aa_ok = 1'b1;
      end
      PO_BC: begin
        ctl       = base(OPC_BR);
        ctl.imm   = IMM_W14;
        ctl.br    = 1'b1;
        ctl.aa_ok = 1'b1;
        ctl.cr    = CRM_BI;
      end
      PO_XL: begin
        if (xo10 == XO_BCLR || xo10 == XO_BCCTR) begin
          ctl     = base(OPC_BR);
          ctl.br  = 1'b1;
          ctl.cr  = CRM_BI;
          ctl.spr = (xo10 == XO_BCLR) ? SPR_LINK : SPR_COUNT;
        end else if (xo10 == XO_CRAND) begin
          ctl    = base(OPC_CRL);
          ctl.cr = CRM_LOGIC;
        end
      end
      PO_X: begin
        case (xo10)
          XO_ADD: begin
            ctl       = base(OPC_ADD);
            ctl.wr    = WR_RT;
            ctl.r1    = R1_RA;
            ctl.r2_rb = 1'b1;
            ctl.rc    = RC_BIT;
          end
          XO_AND, XO_OR: begin
            ctl       = logic_imm((xo10 == XO_AND) ? OPC_AND : OPC_OR, IMM_NONE, RC_BIT);
            ctl.r2_rb = 1'b1;
          end
          XO_LWZX, XO_STWX: begin
            ctl       = ldst(xo10 == XO_STWX, 4'd4, 1'b0, IMM_NONE);
            ctl.r2_rb = 1'b1;
          end
          XO_CMP: begin
            ctl       = base(OPC_CMP);
            ctl.r1    = R1_RA;
            ctl.r2_rb = 1'b1;
            ctl.cr    = CRM_CMP;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
    if (word == NOP_WORD) begin
      ctl     = base(OPC_NOP);
      ctl.nop = 1'b1;
    end
  end
endmodule

// File: rtl/pwr_dec_route.sv
module pwr_dec_route
  import pwr_dec_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int REG_AW = 5,
  parameter int CRF_AW = 3
) (
  input  logic [25:0]       fld,
  input  ctl_t              ctl,
  output logic [3:0]        op_code,
  output logic              illegal,
  output logic              nop,
  output logic [REG_AW-1:0] wr_sel,
  output logic              wr_vld,
  output logic [REG_AW-1:0] rd1_sel,
  output logic              rd1_vld,
  output logic [REG_AW-1:0] rd2_sel,
  output logic              rd2_vld,
  output logic [REG_AW-1:0] rd3_sel,
  output logic              rd3_vld,
  output logic [XLEN-1:0]   imm,
  output logic              rec,
  output logic              upd,
  output logic              lnk,
  output logic              absb,
  output logic [3:0]        acc_size,
  output logic [1:0]        spr_sel,
  output logic [CRF_AW-1:0] crw_sel,
  output logic              crw_vld,
  output logic [CRF_AW-1:0] crr1_sel,
  output logic              crr1_vld,
  output logic [CRF_AW-1:0] crr2_sel,
  output logic              crr2_vld,
  output logic [CRF_AW-1:0] crr3_sel,
  output logic              crr3_vld,
  output logic [4:0]        bo,
  output logic [4:0]        bi,
  output logic [4:0]        sh,
  output logic [4:0]        mb,
  output logic [4:0]        me
);
  logic [REG_AW-1:0] f_rt, f_ra, f_rb;
  logic [CRF_AW-1:0] f_crt, f_cra, f_crb;

  assign f_rt  = fld[25:21];
  assign f_ra  = fld[20:16];
  assign f_rb  = fld[15:11];
  assign f_crt = fld[25:23];
  assign f_cra = fld[20:18];
  assign f_crb = fld[15:13];

  function automatic logic [XLEN-1:0] expand(imm_e m, logic [25:0] w);
    case (m)
      IMM_UI:  return XLEN'(w[15:0]);
      IMM_UIH: return XLEN'({w[15:0], 16'h0000});
      IMM_SI:  return XLEN'($signed(w[15:0]));
      IMM_SIH: return XLEN'($signed({w[15:0], 16'h0000}));
      IMM_W14: return XLEN'($signed({w[15:2], 2'b00}));
      IMM_LI:  return XLEN'($signed({w[25:2], 2'b00}));
      default: return '0;
    endcase
  endfunction

  assign op_code  = ctl.op;
  assign illegal  = ctl.ill;
  assign nop      = ctl.nop;
  assign imm      = expand(ctl.imm, fld);
  assign upd      = ctl.upd;
  assign acc_size = ctl.size;
  assign spr_sel  = ctl.spr;
  assign lnk      = ctl.br & fld[0];
  assign absb     = ctl.aa_ok & fld[1];
  assign bo       = fld[25:21];
  assign bi       = fld[20:16];
  assign sh       = fld[15:11];
  assign mb       = fld[10:6];
  assign me       = fld[5:1];

  always_comb begin
    case (ctl.rc)
      RC_ONE:  rec = 1'b1;
      RC_BIT:  rec = fld[0];
      default: rec = 1'b0;
    endcase
  end

  always_comb begin
    wr_vld = (ctl.wr != WR_NONE);
    case (ctl.wr)
      WR_RT:   wr_sel = f_rt;
      WR_RA:   wr_sel = f_ra;
      default: wr_sel = '0;
    endcase
    case (ctl.r1)
      R1_RA:   rd1_vld = 1'b1;
      R1_RA0:  rd1_vld = (f_ra != '0);
      default: rd1_vld = 1'b0;
    endcase
    rd1_sel = rd1_vld ? f_ra : '0;
    rd2_vld = ctl.r2_rb;
    rd2_sel = ctl.r2_rb ? f_rb : '0;
    rd3_vld = ctl.r3_rs;
    rd3_sel = ctl.r3_rs ? f_rt : '0;
  end

  always_comb begin
    crw_sel  = '0; crw_vld  = 1'b0;
    crr1_sel = '0; crr1_vld = 1'b0;
    crr2_sel = '0; crr2_vld = 1'b0;
    crr3_sel = '0; crr3_vld = 1'b0;
    case (ctl.cr)
      CRM_CMP: begin
        crw_sel = f_crt; crw_vld = 1'b1;
      end
      CRM_BI: begin
        crr1_sel = f_cra; crr1_vld = 1'b1;
      end
      CRM_LOGIC: begin
        crr1_sel = f_cra; crr1_vld = 1'b1;
        crr2_sel = f_crb; crr2_vld = 1'b1;
        crr3_sel = f_crt; crr3_vld = 1'b1;
        crw_sel  = f_crt; crw_vld  = 1'b1;
      end
      default: ;
    endcase
  end

  // Checks relating the class decision to the routed outputs.
  always_comb begin
    if (ctl.ill) begin
      a_r4_illegal_quiet: assert (!(wr_vld | rd1_vld | rd2_vld | rd3_vld |
                                    crw_vld | crr1_vld | crr2_vld | crr3_vld) &&
                                  imm == '0 && acc_size == 4'd0);
    end
    if (ctl.nop) begin
      a_r3_nop_quiet: assert (!(wr_vld | rd1_vld | rd2_vld | rd3_vld) && op_code == 4'd1);
    end
    if (ctl.op == OPC_STORE) begin
      a_r6_store_source: assert (!wr_vld && rd3_vld && rd3_sel == fld[25:21]);
    end
    a_r9_size_only_mem: assert ((acc_size != 4'd0) ==
                                (ctl.op == OPC_LOAD || ctl.op == OPC_STORE));
    if (ctl.imm == IMM_SI) begin
      a_r5_si_sign: assert (imm[XLEN-1:15] == '0 || imm[XLEN-1:15] == '1);
    end
    if (ctl.cr == CRM_LOGIC) begin
      a_r12_cr_target: assert (crw_vld && crr3_vld && crw_sel == crr3_sel);
    end
  end
endmodule

// File: rtl/pwr_subset_decoder.sv
module pwr_subset_decoder
  import pwr_dec_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int XLEN   = 64,
  parameter int REG_AW = 5,
  parameter int CRF_AW = 3
) (
  input  logic [INSN_W-1:0] insn_raw,
  input  logic              big_endian,
  output logic [3:0]        op_code,
  output logic              illegal,
  output logic              nop,
  output logic [REG_AW-1:0] wr_sel,
  output logic              wr_vld,
  output logic [REG_AW-1:0] rd1_sel,
  output logic              rd1_vld,
  output logic [REG_AW-1:0] rd2_sel,
  output logic              rd2_vld,
  output logic [REG_AW-1:0] rd3_sel,
  output logic              rd3_vld,
  output logic [XLEN-1:0]   imm,
  output logic              rec,
  output logic              upd,
  output logic              lnk,
  output logic              absb,
  output logic [3:0]        acc_size,
  output logic [1:0]        spr_sel,
  output logic [CRF_AW-1:0] crw_sel,
  output logic              crw_vld,
  output logic [CRF_AW-1:0] crr1_sel,
  output logic              crr1_vld,
  output logic [CRF_AW-1:0] crr2_sel,
  output logic              crr2_vld,
  output logic [CRF_AW-1:0] crr3_sel,
  output logic              crr3_vld,
  output logic [4:0]        bo,
  output logic [4:0]        bi,
  output logic [4:0]        sh,
  output logic [4:0]        mb,
  output logic [4:0]        me
);
  logic [INSN_W-1:0] word;
  ctl_t              ctl;

  pwr_dec_swap #(.INSN_W(INSN_W)) u_swap (
    .raw(insn_raw), .big_endian(big_endian), .word(word)
  );

  pwr_dec_class u_class (.word(word[31:0]), .ctl(ctl));

  pwr_dec_route #(.XLEN(XLEN), .REG_AW(REG_AW), .CRF_AW(CRF_AW)) u_route (
    .fld(word[25:0]), .ctl(ctl),
    .op_code(op_code), .illegal(illegal), .nop(nop),
    .wr_sel(wr_sel), .wr_vld(wr_vld),
    .rd1_sel(rd1_sel), .rd1_vld(rd1_vld),
    .rd2_sel(rd2_sel), .rd2_vld(rd2_vld),
    .rd3_sel(rd3_sel), .rd3_vld(rd3_vld),
    .imm(imm), .rec(rec), .upd(upd), .lnk(lnk), .absb(absb),
    .acc_size(acc_size), .spr_sel(spr_sel),
    .crw_sel(crw_sel), .crw_vld(crw_vld),
    .crr1_sel(crr1_sel), .crr1_vld(crr1_vld),
    .crr2_sel(crr2_sel), .crr2_vld(crr2_vld),
    .crr3_sel(crr3_sel), .crr3_vld(crr3_vld),
    .bo(bo), .bi(bi), .sh(sh), .mb(mb), .me(me)
  );
endmodule

// File: tb/pwr_subset_decoder_bench.sv
module pwr_subset_decoder_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] insn_raw = '0;
  logic        big_endian = 1'b1;
  logic [3:0]  op_code, acc_size;
  logic        illegal, nop, wr_vld, rd1_vld, rd2_vld, rd3_vld;
  logic [4:0]  wr_sel, rd1_sel, rd2_sel, rd3_sel, bo, bi, sh, mb, me;
  logic [63:0] imm;
  logic        rec, upd, lnk, absb, crw_vld, crr1_vld, crr2_vld, crr3_vld;
  logic [1:0]  spr_sel;
  logic [2:0]  crw_sel, crr1_sel, crr2_sel, crr3_sel;

  pwr_subset_decoder u_pwr_subset_decoder (
    .insn_raw(insn_raw), .big_endian(big_endian),
    .op_code(op_code), .illegal(illegal), .nop(nop),
    .wr_sel(wr_sel), .wr_vld(wr_vld), .rd1_sel(rd1_sel), .rd1_vld(rd1_vld),
    .rd2_sel(rd2_sel), .rd2_vld(rd2_vld), .rd3_sel(rd3_sel), .rd3_vld(rd3_vld),
    .imm(imm), .rec(rec), .upd(upd), .lnk(lnk), .absb(absb),
    .acc_size(acc_size), .spr_sel(spr_sel),
    .crw_sel(crw_sel), .crw_vld(crw_vld), .crr1_sel(crr1_sel), .crr1_vld(crr1_vld),
    .crr2_sel(crr2_sel), .crr2_vld(crr2_vld), .crr3_sel(crr3_sel), .crr3_vld(crr3_vld),
    .bo(bo), .bi(bi), .sh(sh), .mb(mb), .me(me)
  );

  typedef struct {
    logic [31:0] w;
    logic [31:0] raw;
    logic        be;
    string       tag;
    logic [3:0]  op;
    logic        ill, nop;
    logic [4:0]  wr, r1, r2, r3;
    logic        wv, r1v, r2v, r3v;
    logic [63:0] imm;
    logic        rec, upd, lnk, ab;
    logic [3:0]  sz;
    logic [1:0]  spr;
    logic [2:0]  cw, c1, c2, c3;
    logic        cwv, c1v, c2v, c3v;
  } exp_t;

  exp_t sb_q[$];
  exp_t e;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  function automatic logic [31:0] brev(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic exp_t blank(logic [31:0] w, string tag, logic [3:0] op);
    exp_t x;
    x = '{w: w, raw: w, be: 1'b1, tag: tag, op: op, ill: 1'b0, nop: 1'b0,
          wr: 5'd0, r1: 5'd0, r2: 5'd0, r3: 5'd0,
          wv: 1'b0, r1v: 1'b0, r2v: 1'b0, r3v: 1'b0, imm: 64'd0,
          rec: 1'b0, upd: 1'b0, lnk: 1'b0, ab: 1'b0, sz: 4'd0, spr: 2'd0,
          cw: 3'd0, c1: 3'd0, c2: 3'd0, c3: 3'd0,
          cwv: 1'b0, c1v: 1'b0, c2v: 1'b0, c3v: 1'b0};
    return x;
  endfunction

  function automatic logic [31:0] enc_d(int po, int rt, int ra, int im);
    return {po[5:0], rt[4:0], ra[4:0], im[15:0]};
  endfunction
  function automatic logic [31:0] enc_x(int xo, int rs, int ra, int rb, int rc);
    return {6'd31, rs[4:0], ra[4:0], rb[4:0], xo[9:0], rc[0]};
  endfunction
  function automatic logic [31:0] enc_m(int po, int rs, int ra, int s, int b, int en, int rc);
    return {po[5:0], rs[4:0], ra[4:0], s[4:0], b[4:0], en[4:0], rc[0]};
  endfunction
  function automatic logic [31:0] enc_xl(int xo, int o, int i, int lk);
    return {6'd19, o[4:0], i[4:0], 5'd0, xo[9:0], lk[0]};
  endfunction

  // Driver: one item per rising edge, in both byte orders.
  task automatic push_one(exp_t x);
    @(posedge clk);
    insn_raw   = x.raw;
    big_endian = x.be;
    sb_q.push_back(x);
  endtask

  task automatic drive(exp_t x);
    exp_t y;
    push_one(x);
    y     = x;
    y.be  = 1'b0;
    y.raw = brev(x.w);
    push_one(y);
  endtask

  task automatic cmp(string f, logic [63:0] g, logic [63:0] x, string tag, inout bit bad);
    if (g !== x) begin
      $display("FAIL %s %s raw=%h: got %h expected %h", tag, f, insn_raw, g, x);
      bad = 1'b1;
    end
  endtask

  // Monitor: compares away from the driving edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0 && !finished) begin
      exp_t x;
      bit bad;
      x = sb_q.pop_front();
      bad = 1'b0;
      cmp("op_code", 64'(op_code), 64'(x.op), x.tag, bad);
      cmp("illegal", 64'(illegal), 64'(x.ill), x.tag, bad);
      cmp("nop", 64'(nop), 64'(x.nop), x.tag, bad);
      cmp("wr", 64'({wr_vld, wr_sel}), 64'({x.wv, x.wr}), x.tag, bad);
      cmp("rd1", 64'({rd1_vld, rd1_sel}), 64'({x.r1v, x.r1}), x.tag, bad);
      cmp("rd2", 64'({rd2_vld, rd2_sel}), 64'({x.r2v, x.r2}), x.tag, bad);
      cmp("rd3", 64'({rd3_vld, rd3_sel}), 64'({x.r3v, x.r3}), x.tag, bad);
      cmp("imm", imm, x.imm, x.tag, bad);
      cmp("flags", 64'({rec, upd, lnk, absb}), 64'({x.rec, x.upd, x.lnk, x.ab}), x.tag, bad);
      cmp("size", 64'(acc_size), 64'(x.sz), x.tag, bad);
      cmp("spr", 64'(spr_sel), 64'(x.spr), x.tag, bad);
      cmp("crw", 64'({crw_vld, crw_sel}), 64'({x.cwv, x.cw}), x.tag, bad);
      cmp("crr1", 64'({crr1_vld, crr1_sel}), 64'({x.c1v, x.c1}), x.tag, bad);
      cmp("crr2", 64'({crr2_vld, crr2_sel}), 64'({x.c2v, x.c2}), x.tag, bad);
      cmp("crr3", 64'({crr3_vld, crr3_sel}), 64'({x.c3v, x.c3}), x.tag, bad);
      cmp("raw_fields", 64'({bo, bi, sh, mb, me}),
          64'({x.w[25:21], x.w[20:16], x.w[15:11], x.w[10:6], x.w[5:1]}), x.tag, bad);
      n_checks++;
      if (bad) n_fail++;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    // R4 reset-like idle state: all-zero word is primary opcode 0, illegal
    e = blank(32'h0, "R4_zero_word", 4'd0); e.ill = 1; drive(e);

    // R5 R6 addi with negative immediate
    e = blank(enc_d(14, 3, 4, 'h8001), "R5_addi", 4'd2);
    e.wv = 1; e.wr = 3; e.r1v = 1; e.r1 = 4; e.imm = 64'hFFFF_FFFF_FFFF_8001; drive(e);
    // R6 addis with RA=0 -> no read
    e = blank(enc_d(15, 5, 0, 'h1234), "R6_addis_ra0", 4'd2);
    e.wv = 1; e.wr = 5; e.imm = 64'h0000_0000_1234_0000; drive(e);
    e = blank(enc_d(15, 6, 2, 'h8000), "R5_addis_neg", 4'd2);
    e.wv = 1; e.wr = 6; e.r1v = 1; e.r1 = 2; e.imm = 64'hFFFF_FFFF_8000_0000; drive(e);
    // R7 logical immediates
    e = blank(enc_d(24, 7, 9, 'hBEEF), "R7_ori", 4'd4);
    e.wv = 1; e.wr = 9; e.r3v = 1; e.r3 = 7; e.imm = 64'h0000_0000_0000_BEEF; drive(e);
    e = blank(enc_d(25, 1, 2, 'hF00D), "R5_oris", 4'd4);
    e.wv = 1; e.wr = 2; e.r3v = 1; e.r3 = 1; e.imm = 64'h0000_0000_F00D_0000; drive(e);
    e = blank(enc_d(28, 10, 11, 'h00FF), "R8_andi_rec", 4'd3);
    e.wv = 1; e.wr = 11; e.r3v = 1; e.r3 = 10; e.imm = 64'hFF; e.rec = 1; drive(e);
    // R3 no-op and near miss
    e = blank(32'h6000_0000, "R3_nop", 4'd1); e.nop = 1; drive(e);
    e = blank(32'h6400_0000, "R3_oris_zero", 4'd4);
    e.wv = 1; e.wr = 0; e.r3v = 1; e.r3 = 0; drive(e);

    // R6 R9 loads and stores
    e = blank(enc_d(32, 6, 7, 'hFFFC), "R6_lwz", 4'd5);
    e.wv = 1; e.wr = 6; e.r1v = 1; e.r1 = 7; e.imm = 64'hFFFF_FFFF_FFFF_FFFC; e.sz = 4; drive(e);
    e = blank(enc_d(33, 8, 0, 'h0010), "R9_lwzu_ra0", 4'd5);
    e.wv = 1; e.wr = 8; e.r1v = 1; e.r1 = 0; e.imm = 64'h10; e.sz = 4; e.upd = 1; drive(e);
    e = blank(enc_d(34, 3, 0, 'h0001), "R9_lbz", 4'd5);
    e.wv = 1; e.wr = 3; e.imm = 1; e.sz = 1; drive(e);
    e = blank(enc_d(40, 4, 5, 'h7FFF), "R9_lhz", 4'd5);
    e.wv = 1; e.wr = 4; e.r1v = 1; e.r1 = 5; e.imm = 64'h7FFF; e.sz = 2; drive(e);
    e = blank(enc_d(36, 13, 14, 'h0008), "R6_stw", 4'd6);
    e.r3v = 1; e.r3 = 13; e.r1v = 1; e.r1 = 14; e.imm = 8; e.sz = 4; drive(e);
    e = blank(enc_d(37, 15, 16, 'hFFF0), "R9_stwu", 4'd6);
    e.r3v = 1; e.r3 = 15; e.r1v = 1; e.r1 = 16; e.imm = 64'hFFFF_FFFF_FFFF_FFF0; e.sz = 4; e.upd = 1; drive(e);
    e = blank(enc_d(38, 17, 18, 'h0002), "R9_stb", 4'd6);
    e.r3v = 1; e.r3 = 17; e.r1v = 1; e.r1 = 18; e.imm = 2; e.sz = 1; drive(e);
    e = blank(enc_d(44, 19, 0, 'h0004), "R9_sth_ra0", 4'd6);
    e.r3v = 1; e.r3 = 19; e.imm = 4; e.sz = 2; drive(e);
    e = blank(enc_d(58, 3, 4, 'hFFF8), "R5_ld_ds", 4'd5);
    e.wv = 1; e.wr = 3; e.r1v = 1; e.r1 = 4; e.imm = 64'hFFFF_FFFF_FFFF_FFF8; e.sz = 8; drive(e);
    e = blank(enc_d(62, 20, 21, 'h0104), "R9_std", 4'd6);
    e.r3v = 1; e.r3 = 20; e.r1v = 1; e.r1 = 21; e.imm = 64'h104; e.sz = 8; drive(e);
    // R2 extended opcode in [1:0]: XO 1 under 58 is not in the subset
    e = blank(enc_d(58, 3, 4, 'h0009), "R2_ds_xo1", 4'd0); e.ill = 1; drive(e);

    // R7 R8 X-form
    e = blank(enc_x(266, 1, 2, 3, 0), "R7_add", 4'd2);
    e.wv = 1; e.wr = 1; e.r1v = 1; e.r1 = 2; e.r2v = 1; e.r2 = 3; drive(e);
    e = blank(enc_x(266, 1, 0, 3, 1), "R8_add_dot", 4'd2);
    e.wv = 1; e.wr = 1; e.r1v = 1; e.r1 = 0; e.r2v = 1; e.r2 = 3; e.rec = 1; drive(e);
    e = blank(enc_x(28, 4, 5, 6, 0), "R7_and", 4'd3);
    e.wv = 1; e.wr = 5; e.r3v = 1; e.r3 = 4; e.r2v = 1; e.r2 = 6; drive(e);
    e = blank(enc_x(444, 7, 8, 9, 1), "R7_or_dot", 4'd4);
    e.wv = 1; e.wr = 8; e.r3v = 1; e.r3 = 7; e.r2v = 1; e.r2 = 9; e.rec = 1; drive(e);
    e = blank(enc_x(23, 10, 0, 12, 0), "R6_lwzx_ra0", 4'd5);
    e.wv = 1; e.wr = 10; e.r2v = 1; e.r2 = 12; e.sz = 4; drive(e);
    e = blank(enc_x(151, 13, 14, 15, 0), "R6_stwx", 4'd6);
    e.r3v = 1; e.r3 = 13; e.r1v = 1; e.r1 = 14; e.r2v = 1; e.r2 = 15; e.sz = 4; drive(e);
    e = blank({6'd31, 3'd5, 2'd0, 5'd16, 5'd17, 10'd0, 1'b0}, "R12_cmp_bf", 4'd7);
    e.r1v = 1; e.r1 = 16; e.r2v = 1; e.r2 = 17; e.cwv = 1; e.cw = 5; drive(e);
    e = blank(enc_x(778, 1, 2, 3, 0), "R2_add_oe_set", 4'd0); e.ill = 1; drive(e);

    // R13 rotates
    e = blank(enc_m(21, 4, 5, 7, 8, 31, 1), "R13_rlwinm_dot", 4'd8);
    e.wv = 1; e.wr = 5; e.r3v = 1; e.r3 = 4; e.rec = 1; drive(e);
    e = blank(enc_m(23, 9, 10, 6, 0, 15, 0), "R13_rlwnm", 4'd8);
    e.wv = 1; e.wr = 10; e.r3v = 1; e.r3 = 9; e.r2v = 1; e.r2 = 6; drive(e);
    e = blank(enc_m(20, 11, 12, 3, 16, 23, 0), "R13_rlwimi", 4'd8);
    e.wv = 1; e.wr = 12; e.r3v = 1; e.r3 = 11; drive(e);

    // R10 branches
    e = blank({6'd18, 24'h012345, 1'b0, 1'b1}, "R10_b_link", 4'd9);
    e.imm = 64'h48D14; e.lnk = 1; drive(e);
    e = blank({6'd18, 24'hFFFFFF, 1'b1, 1'b0}, "R10_b_abs_neg", 4'd9);
    e.imm = 64'hFFFF_FFFF_FFFF_FFFC; e.ab = 1; drive(e);
    e = blank({6'd16, 5'd12, 5'd9, 14'h0010, 1'b1, 1'b1}, "R10_bc", 4'd9);
    e.imm = 64'h40; e.lnk = 1; e.ab = 1; e.c1v = 1; e.c1 = 2; drive(e);
    // R11 register-target branches
    e = blank(enc_xl(16, 20, 30, 1), "R11_bclr_l", 4'd9);
    e.spr = 1; e.lnk = 1; e.c1v = 1; e.c1 = 7; drive(e);
    e = blank(enc_xl(528, 12, 1, 0), "R11_bcctr", 4'd9);
    e.spr = 2; e.c1v = 1; e.c1 = 0; drive(e);
    // R12 CR logical
    e = blank({6'd19, 5'd13, 5'd6, 5'd31, 10'd257, 1'b0}, "R12_crand", 4'd10);
    e.c1v = 1; e.c1 = 1; e.c2v = 1; e.c2 = 7; e.c3v = 1; e.c3 = 3; e.cwv = 1; e.cw = 3; drive(e);
    // R4 unknown encodings
    e = blank(enc_xl(300, 1, 2, 0), "R4_xl_unknown", 4'd0); e.ill = 1; drive(e);
    e = blank({6'd30, 26'h0ABCDEF}, "R4_po30", 4'd0); e.ill = 1; drive(e);

    // R1 R3 byte order meets no-op detection in the same word
    e = blank(32'h6000_0000, "R1_swapped_nop", 4'd1);
    e.nop = 1; e.raw = 32'h0000_0060; e.be = 1'b0; push_one(e);
    e = blank(32'h0000_0060, "R1_swapped_to_illegal", 4'd0);
    e.ill = 1; e.raw = 32'h6000_0000; e.be = 1'b0; push_one(e);

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule